// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits beside one hart's load/store path and decides whether a store-conditional may write memory. A load-reserved request arms a single reservation on the 64-byte line that holds its address. A later store-conditional to the same line succeeds only if that reservation is still armed. Any write by another agent, seen as an address on the snoop port, disarms the reservation when it falls in the reserved line.

For every store-conditional the block answers one cycle later. It raises a store-enable pulse toward memory when the store may proceed. It also returns the value to be written to the destination register: zero on success and one on failure. A test input can force any store-conditional to fail, which exercises software retry loops. The cache, the coherence protocol states and the other atomic operations are handled elsewhere.

Top module: `lrsc_resv_monitor`

## Requirements
- R1: After reset no reservation is held, and sc_rsp_valid and sc_store_en are 0 and sc_rsp_status is all zeros.
- R2: An SC (req_valid=1, req_kind=2'b10) to the line reserved by an earlier LR (req_kind=2'b01) succeeds. In the next cycle sc_rsp_valid=1, sc_store_en=1 and sc_rsp_status=0.
- R3: A failing SC gives sc_rsp_valid=1, sc_store_en=0 and sc_rsp_status=1 in the next cycle. An SC whose line differs from the reserved line fails.
- R4: An SC issued while no reservation is held fails and performs no store.
- R5: A snoop write (snoop_valid=1) whose line equals the reserved line clears the reservation. A snoop to any other line leaves the reservation in place.
- R6: Line comparison ignores address bits [5:0], so any byte offset inside the 64-byte line matches.
- R7: Every SC clears the reservation, whether it succeeds or fails.
- R8: An SC issued with sc_force_fail=1 fails, and it still clears the reservation.
- R9: When a matching snoop and an SC arrive in the same cycle, the snoop takes priority and the SC fails.
- R10: A new LR replaces any earlier reservation. After it, only the newly reserved line can succeed.
- R11: sc_rsp_valid pulses for exactly one cycle after each SC and never at any other time. sc_store_en is high only in the response cycle of a successful SC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 2'b01 load-reserved, 2'b10 store-conditional, other codes ignored |
| req_addr | input | ADDR_W | Byte address of the request |
| snoop_valid | input | 1 | Write by another agent seen this cycle |
| snoop_addr | input | ADDR_W | Byte address of the snooped write |
| sc_force_fail | input | 1 | Forces a store-conditional issued this cycle to fail |
| sc_rsp_valid | output | 1 | Store-conditional response present |
| sc_store_en | output | 1 | Store may be performed |
| sc_rsp_status | output | XLEN | Destination value: 0 on success, 1 on failure |

## Verification
On every cycle the assertions check several relations. The status value always agrees with the store-enable. A response only follows a store-conditional. A store never proceeds without a reservation, and never under forced failure or a same-cycle matching snoop. Each store-conditional and each matching snoop leaves the reservation cleared, and a load-reserved arms it with its own line. Other behaviour needs the bench's multi-step scenarios to show it. These are the line-offset masking, the survival of a reservation across snoops to unrelated lines, the replacement of an old line by a newer load-reserved, and the end-to-end retry sequences.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_LR   = 2'b01,
    KIND_SC   = 2'b10,
    KIND_RSVD = 2'b11
  } req_kind_e;
endpackage

// File: rtl/lrsc_line_match.sv
module lrsc_line_match #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6,
  localparam int TAG_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [TAG_W-1:0]  addr_tag_o,
  output logic              hit_o
);
  // Line tag is the address with the byte offset dropped.
  generate
    if (OFS_W > 0) begin : g_strip
      assign addr_tag_o = addr_i[ADDR_W-1:OFS_W];
    end else begin : g_full
      assign addr_tag_o = addr_i;
    end
  endgenerate

  assign hit_o = (addr_tag_o == tag_i);
endmodule

// File: rtl/lrsc_resv_slot.sv
module lrsc_resv_slot #(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             clear_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  // A new reservation takes priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      tag_o   <= tag_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end

  p_lr_arms_line_r10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (valid_o && tag_o == $past(tag_i)));

  p_clear_disarms_r7: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !set_i) |=> !valid_o);
endmodule

// File: rtl/lrsc_resv_monitor.sv
module lrsc_resv_monitor #(
  parameter int ADDR_W     = 32,
  parameter int XLEN       = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              sc_force_fail,
  output logic              sc_rsp_valid,
  output logic              sc_store_en,
  output logic [XLEN-1:0]   sc_rsp_status
);
  import lrsc_pkg::*;

  logic             is_lr, is_sc;
  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;
  logic [TAG_W-1:0] req_tag, snoop_tag;
  logic             req_hit, snoop_line_hit;
  logic             snoop_kill, sc_ok, resv_clear;

  assign is_lr = req_valid && (req_kind_e'(req_kind) == KIND_LR);
  assign is_sc = req_valid && (req_kind_e'(req_kind) == KIND_SC);

  lrsc_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_req_match (
    .addr_i     (req_addr),
    .tag_i      (resv_tag),
    .addr_tag_o (req_tag),
    .hit_o      (req_hit)
  );

  lrsc_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_snoop_match (
    .addr_i     (snoop_addr),
    .tag_i      (resv_tag),
    .addr_tag_o (snoop_tag),
    .hit_o      (snoop_line_hit)
  );

  // A snoop to the armed line kills the reservation and beats a racing SC.
  assign snoop_kill = snoop_valid && resv_valid && snoop_line_hit;
  assign sc_ok      = is_sc && resv_valid && req_hit && !snoop_kill && !sc_force_fail;
  assign resv_clear = is_sc || snoop_kill;

  lrsc_resv_slot #(.TAG_W(TAG_W)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .set_i   (is_lr),
    .tag_i   (req_tag),
    .clear_i (resv_clear),
    .valid_o (resv_valid),
    .tag_o   (resv_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_rsp_valid  <= 1'b0;
      sc_store_en   <= 1'b0;
      sc_rsp_status <= '0;
    end else begin
      sc_rsp_valid  <= is_sc;
      sc_store_en   <= sc_ok;
      sc_rsp_status <= (is_sc && !sc_ok) ? XLEN'(1) : '0;
    end
  end

  p_store_in_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    sc_store_en |-> sc_rsp_valid);

  p_rsp_after_sc_r11: assert property (@(posedge clk) disable iff (rst)
    sc_rsp_valid |-> $past(is_sc));

  p_status_code_r3: assert property (@(posedge clk) disable iff (rst)
    sc_rsp_valid |-> (sc_rsp_status == (sc_store_en ? XLEN'(0) : XLEN'(1))));

  p_no_resv_fails_r4: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !resv_valid) |=> !sc_store_en);

  p_forced_fail_r8: assert property (@(posedge clk) disable iff (rst)
    (is_sc && sc_force_fail) |=> !sc_store_en);

  p_snoop_race_r9: assert property (@(posedge clk) disable iff (rst)
    (is_sc && snoop_kill) |=> !sc_store_en);

  p_snoop_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (snoop_kill && !is_lr) |=> !resv_valid);
endmodule

// File: tb/lrsc_resv_monitor_tb.sv
module lrsc_resv_monitor_tb;
  localparam int ADDR_W = 32;
  localparam int XLEN   = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [1:0]        req_kind = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              snoop_valid = 1'b0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic              sc_force_fail = 1'b0;
  logic              sc_rsp_valid, sc_store_en;
  logic [XLEN-1:0]   sc_rsp_status;

  int checks = 0;
  int errors = 0;
  int exp_succ = 0;
  int seen_pulses = 0;
  bit mon_on = 1'b0;

  typedef struct { bit ok; string req; } exp_t;
  exp_t sb[$];

  localparam logic [ADDR_W-1:0] LINE_A = 32'h0000_1200;
  localparam logic [ADDR_W-1:0] LINE_B = 32'h0000_5680;

  lrsc_resv_monitor u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .sc_force_fail(sc_force_fail), .sc_rsp_valid(sc_rsp_valid),
    .sc_store_en(sc_store_en), .sc_rsp_status(sc_rsp_status)
  );

  always #5 clk = ~clk;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus, applied at the falling edge.
  task automatic drive(input logic [1:0] kind, input logic [ADDR_W-1:0] addr,
                       input bit sv, input logic [ADDR_W-1:0] saddr,
                       input bit ff, input bit ok, input string req);
    @(negedge clk);
    req_valid     = (kind != 2'b00);
    req_kind      = kind;
    req_addr      = addr;
    snoop_valid   = sv;
    snoop_addr    = saddr;
    sc_force_fail = ff;
    if (kind == 2'b10) begin
      exp_t e;
      e.ok = ok; e.req = req;
      sb.push_back(e);
      if (ok) exp_succ++;
    end
  endtask

  task automatic idle();
    drive(2'b00, '0, 1'b0, '0, 1'b0, 1'b0, "");
  endtask

  task automatic lr(input logic [ADDR_W-1:0] a);
    drive(2'b01, a, 1'b0, '0, 1'b0, 1'b0, "");
  endtask

  task automatic sc(input logic [ADDR_W-1:0] a, input bit ok, input string req);
    drive(2'b10, a, 1'b0, '0, 1'b0, ok, req);
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a);
    drive(2'b00, '0, 1'b1, a, 1'b0, 1'b0, "");
  endtask

  // Scoreboard monitor: pops one expected item per response.
  always @(negedge clk) begin
    if (mon_on) begin
      if (sc_store_en) seen_pulses++;
      if (sc_rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11", "unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(sc_store_en == e.ok, e.req, "store enable", 32'(sc_store_en), 32'(e.ok));
          check(sc_rsp_status == (e.ok ? 32'd0 : 32'd1), e.req, "status",
                sc_rsp_status, e.ok ? 32'd0 : 32'd1);
        end
      end else if (sc_store_en) begin
        check(1'b0, "R11", "store enable outside response", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs idle after reset
    check(sc_rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(sc_rsp_valid), 32'd0);
    check(sc_store_en == 1'b0, "R1", "store_en after reset", 32'(sc_store_en), 32'd0);
    check(sc_rsp_status == '0, "R1", "status after reset", sc_rsp_status, 32'd0);
    mon_on = 1'b1;

    sc(LINE_A, 1'b0, "R4");                 // R4 / R1: nothing reserved
    idle();
    lr(LINE_A); sc(LINE_A, 1'b1, "R2");     // R2 basic success
    sc(LINE_A, 1'b0, "R7");                 // R7: consumed by success
    idle();
    lr(LINE_A); sc(LINE_A + 32'h3C, 1'b1, "R6");   // R6 offset ignored
    lr(LINE_A + 32'h11); sc(LINE_A + 32'h2, 1'b1, "R6");
    lr(LINE_A); sc(LINE_A + 32'h40, 1'b0, "R3");   // R3 next line differs
    sc(LINE_A, 1'b0, "R7");                 // R7: cleared by failed SC
    lr(LINE_A); snoop(LINE_A + 32'h8); sc(LINE_A, 1'b0, "R5");
    lr(LINE_A); snoop(LINE_B); snoop(LINE_A + 32'h40); sc(LINE_A, 1'b1, "R5");
    lr(LINE_A);
    drive(2'b10, LINE_A, 1'b0, '0, 1'b1, 1'b0, "R8");  // forced failure
    sc(LINE_A, 1'b0, "R8");                 // R8: reservation gone
    lr(LINE_A);
    drive(2'b10, LINE_A, 1'b1, LINE_A + 32'h4, 1'b0, 1'b0, "R9");
    lr(LINE_A); lr(LINE_B); sc(LINE_A, 1'b0, "R10");
    lr(LINE_A); lr(LINE_B); sc(LINE_B, 1'b1, "R10");
    lr(LINE_B); drive(2'b11, LINE_B, 1'b0, '0, 1'b0, 1'b0, ""); sc(LINE_B, 1'b1, "R11");
    idle(); idle(); idle();

    // R11: one store pulse per success, and every response accounted for
    check(seen_pulses == exp_succ, "R11", "store pulse count", 32'(seen_pulses), 32'(exp_succ));
    check(sb.size() == 0, "R11", "responses missing", 32'(sb.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule